// File: doc/BRIEF.md
# Elastic Serial Ciphertext Output Queue

This block sits between a block-oriented keystream/XOR stage and a serial channel. Words of up to `WORD_W` bits arrive from the block side. Each word carries a valid count: either the full word, or only its low `d` bits when the producer emits a partial word. The accepted bits are appended to a circular bit store of `CAP` bits. One bit per clock leaves the store towards the channel, at the same constant rate at which plaintext enters the sending side.

The queue comes out of reset full of filler bits. Its occupancy therefore starts at capacity and falls by one bit per clock until words are appended. When the upstream plaintext queue has the same capacity, the two occupancies add up to `CAP` between resynchronisations.

Two sticky flags report misuse. Underflow is set when the store is empty on a drain clock. Overflow is set when a write carries more bits than the free space.

Top module: `ctq_top`

## Requirements
- R1: While reset is held and directly after its release, `level` equals `CAP`, `ser_bit` is 0, and both flags are 0.
- R2: On every clock after reset with `level` non-zero, one bit is drained. Without a write, `level` falls by exactly one.
- R3: Bits leave in the order they were accepted. Within a word, bit 0 of `wr_data` is the oldest and leaves first, and only the low `d` bits are stored. A drained bit appears on `ser_bit` after the clock edge that drains it.
- R4: A write with count 0 stores nothing.
- R5: A write of `d` bits and a drain in the same clock are both honoured, and `level` changes by `d - 1`.
- R6: A drain clock that finds `level` at 0 makes `ser_bit` 0 for that cycle and sets `underflow`.
- R7: When a write carries more bits than the space left after that clock's drain, only the oldest bits that fit are kept, the rest are dropped, and `overflow` is set.
- R8: The `CAP` filler bits present after reset drain out as 0.
- R9: `underflow` and `overflow` stay set until the next reset.
- R10: A count above `WORD_W` is treated as `WORD_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one channel bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Append the word on `wr_data` this clock |
| wr_cnt | input | $clog2(WORD_W+1) | Number of valid low bits in `wr_data` |
| wr_data | input | WORD_W | Ciphertext word; bit 0 is the oldest |
| ser_bit | output | 1 | Serial ciphertext bit drained on the last edge |
| level | output | $clog2(CAP+1) | Bits currently held |
| underflow | output | 1 | Sticky: drained while empty |
| overflow | output | 1 | Sticky: write exceeded free space |

## Verification
The bench builds the queue with `CAP` = 16 and `WORD_W` = 8. With these values the whole filler drain fits in sixteen clocks, and every count from 0 to 8 can be swept with several data patterns. The store also wraps many times within a short run. The small capacity makes overflow reachable with a single full write at full level, and a 4-bit count field makes out-of-range counts possible. A bit-level queue model in the bench predicts every serial bit, the level and both flags on every clock.

// File: rtl/ctq_pkg.sv
package ctq_pkg;
   // Smaller of two unsigned counts.
   function automatic int unsigned umin(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/ctq_ctrl.sv
module ctq_ctrl #(
   parameter int CAP    = 256,
   parameter int WORD_W = 128,
   localparam int CNT_W = $clog2(WORD_W + 1),
   localparam int LVL_W = $clog2(CAP + 1),
   localparam int PTR_W = $clog2(CAP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_cnt,
   output logic [LVL_W-1:0] level,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [LVL_W-1:0] acc,
   output logic             take,
   output logic             unf,
   output logic             ovf
);
   localparam int SW = LVL_W + 1;

   logic [SW-1:0]    req;
   logic [SW-1:0]    space;
   logic             too_many;
   logic [LVL_W-1:0] level_nx;

   always_comb begin
      req = '0;
      if (wr_en) begin
         if (int'(wr_cnt) > WORD_W) req = SW'(WORD_W);
         else                       req = SW'(wr_cnt);
      end
      take     = (level != '0);
      space    = SW'(CAP) - SW'(level) + SW'(take);
      too_many = (req > space);
      acc      = too_many ? LVL_W'(space) : LVL_W'(req);
      level_nx = level - LVL_W'(take) + acc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level  <= LVL_W'(CAP);
         wr_ptr <= '0;
         rd_ptr <= '0;
         unf    <= 1'b0;
         ovf    <= 1'b0;
      end else begin
         level  <= level_nx;
         wr_ptr <= wr_ptr + PTR_W'(acc);
         rd_ptr <= rd_ptr + PTR_W'(take);
         if (!take)    unf <= 1'b1;
         if (too_many) ovf <= 1'b1;
      end
   end

   // R1
   level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= CAP);

   // R2
   drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && level != '0) |=> int'(level) == int'($past(level)) - 1);

   // R5
   both_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && level != '0 && int'(level) + WORD_W <= CAP && int'(wr_cnt) <= WORD_W)
      |=> int'(level) == int'($past(level)) + int'($past(wr_cnt)) - 1);

   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(wr_en));

   // R9
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> unf);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
endmodule

// File: rtl/ctq_store.sv
module ctq_store #(
   parameter int CAP    = 256,
   parameter int WORD_W = 128,
   localparam int LVL_W = $clog2(CAP + 1),
   localparam int PTR_W = $clog2(CAP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [LVL_W-1:0]  acc,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic              take,
   output logic              ser_bit
);
   logic [CAP-1:0] mem;
   logic [CAP-1:0] wmask;
   logic [CAP-1:0] wval;

   for (genvar j = 0; j < CAP; j++) begin : g_cell
      logic [PTR_W-1:0]  off;
      logic [WORD_W-1:0] shd;
      assign off      = PTR_W'(j) - wr_ptr;
      assign shd      = wr_data >> off;
      assign wmask[j] = (LVL_W'(off) < acc);
      assign wval[j]  = shd[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem     <= '0;
         ser_bit <= 1'b0;
      end else begin
         mem     <= (mem & ~wmask) | (wval & wmask);
         ser_bit <= take ? mem[rd_ptr] : 1'b0;
      end
   end

   // R3
   write_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(acc) <= WORD_W);
endmodule

// File: rtl/ctq_top.sv
module ctq_top #(
   parameter int CAP    = 256,
   parameter int WORD_W = 128,
   localparam int CNT_W = $clog2(WORD_W + 1),
   localparam int LVL_W = $clog2(CAP + 1),
   localparam int PTR_W = $clog2(CAP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CNT_W-1:0]  wr_cnt,
   input  logic [WORD_W-1:0] wr_data,
   output logic              ser_bit,
   output logic [LVL_W-1:0]  level,
   output logic              underflow,
   output logic              overflow
);
   if ((CAP & (CAP - 1)) != 0 || CAP < 2) begin : g_bad_cap
      $error("ctq_top: CAP must be a power of two of at least 2");
   end
   if (WORD_W < 1 || WORD_W > CAP) begin : g_bad_word
      $error("ctq_top: WORD_W must lie in 1..CAP");
   end

   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [LVL_W-1:0] acc;
   logic             take;

   ctq_ctrl #(.CAP(CAP), .WORD_W(WORD_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_cnt (wr_cnt),
      .level  (level),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .acc    (acc),
      .take   (take),
      .unf    (underflow),
      .ovf    (overflow)
   );

   ctq_store #(.CAP(CAP), .WORD_W(WORD_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ptr  (wr_ptr),
      .acc     (acc),
      .wr_data (wr_data),
      .rd_ptr  (rd_ptr),
      .take    (take),
      .ser_bit (ser_bit)
   );

   // R6
   underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(level) == '0) |-> (ser_bit == 1'b0 && underflow));
endmodule

// File: tb/sim_ctq_top.sv
module sim_ctq_top;
   localparam int CLK_NS = 10;
   localparam int CAP    = 16;
   localparam int WORD_W = 8;
   localparam int CNT_W  = $clog2(WORD_W + 1);
   localparam int LVL_W  = $clog2(CAP + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [CNT_W-1:0]  wr_cnt = '0;
   logic [WORD_W-1:0] wr_data = '0;
   logic              ser_bit;
   logic [LVL_W-1:0]  level;
   logic              underflow;
   logic              overflow;

   int n_tests = 0;
   int n_fail  = 0;

   // bench model
   logic mq [0:CAP-1];
   int   mc;
   logic eb, eu, eo;

   always #(CLK_NS/2) clk = ~clk;

   ctq_top #(.CAP(CAP), .WORD_W(WORD_W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cnt(wr_cnt), .wr_data(wr_data),
      .ser_bit(ser_bit), .level(level), .underflow(underflow), .overflow(overflow)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      mc = CAP;
      for (int i = 0; i < CAP; i++) mq[i] = 1'b0;
      eb = 1'b0; eu = 1'b0; eo = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; wr_cnt = '0; wr_data = '0;
      @(negedge clk);
      @(negedge clk);
      model_reset();
      // R1: state while held and straight after release
      chk("R1 level", int'(level), CAP);
      chk("R1 underflow", int'(underflow), 0);
      chk("R1 overflow", int'(overflow), 0);
      chk("R1 ser_bit", int'(ser_bit), 0);
      rst_n = 1'b1;
   endtask

   // One clock: drive at negedge, model the edge, compare at the next negedge.
   task automatic step(input logic we, input int cnt, input int dat, input string ctx);
      int req, space, acc;
      wr_en   = we;
      wr_cnt  = CNT_W'(cnt);
      wr_data = WORD_W'(dat);
      @(posedge clk);
      if (mc > 0) begin
         eb = mq[0];
         for (int i = 0; i < CAP - 1; i++) mq[i] = mq[i+1];
         mc--;
      end else begin
         eb = 1'b0;
         eu = 1'b1;
      end
      req = we ? ((cnt > WORD_W) ? WORD_W : cnt) : 0;
      space = CAP - mc;
      acc = (req > space) ? space : req;
      if (req > space) eo = 1'b1;
      for (int i = 0; i < acc; i++) mq[mc + i] = dat[i];
      mc += acc;
      @(negedge clk);
      wr_en = 1'b0;
      chk({ctx, " R3 ser_bit"}, int'(ser_bit), int'(eb));
      chk({ctx, " R2 level"}, int'(level), mc);
      chk({ctx, " R6 underflow"}, int'(underflow), int'(eu));
      chk({ctx, " R7 overflow"}, int'(overflow), int'(eo));
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      do_reset();

      // R8: filler drains as zeros, level falls to 0
      for (int i = 0; i < CAP; i++) step(1'b0, 0, 0, "R8");
      // R6: drain while empty
      step(1'b0, 0, 0, "R6");
      step(1'b0, 0, 0, "R6");
      // R9: underflow stays set while data flows again
      step(1'b1, 5, 8'h1D, "R9");
      for (int i = 0; i < 6; i++) step(1'b0, 0, 0, "R9");

      do_reset();
      for (int i = 0; i < 12; i++) step(1'b0, 0, 0, "R2");
      // R4, R5, R3: every count with several patterns
      for (int k = 0; k < 3; k++) begin
         for (int d = 0; d <= WORD_W; d++) begin
            step(1'b1, d, (d * 37 + k * 91 + 5) & 8'hFF, (d == 0) ? "R4" : "R5");
            for (int i = 0; i < d - 1; i++) step(1'b0, 0, 0, "R3");
         end
         for (int i = 0; i < 3; i++) step(1'b1, 1, k + i, "R5");
      end
      // R10: count above the word width
      step(1'b1, 15, 8'hB4, "R10");
      step(1'b1, 12, 8'h6B, "R10");
      for (int i = 0; i < 20; i++) step(1'b0, 0, 0, "R3");

      // R7: write into a full queue keeps only the bits that fit
      do_reset();
      step(1'b1, 8, 8'hFF, "R7");
      step(1'b1, 8, 8'hA5, "R7");
      for (int i = 0; i < 6; i++) step(1'b1, 3, 8'h06, "R7");
      // R9: overflow held while draining everything
      for (int i = 0; i < CAP + 2; i++) step(1'b0, 0, 0, "R9");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule